// File: doc/BRIEF.md
# Memory/IO Split Bus Decoder

This block joins a single bus master to two slaves: a main-memory slave and an IO slave. The master issues a request by raising a one-cycle read or write strobe. In that same cycle it presents the address, the write data and two side flags, one for atomic access and one for non-cacheable access. The decoder reads one address bit to choose a slave. It steers the strobe only to that slave, without adding a register stage. The memory port receives a 21-bit address and the IO port receives a 7-bit address. Both ports receive the write data and side flags unchanged.

Each slave answers with a 2-bit count of the cycles still to wait. The transaction is complete when that count reaches zero, and read data is valid in that cycle. The master's address and strobes are only meaningful in the strobe cycle. For that reason the decoder stores which slave took each request. From the next cycle until the next strobe, it routes that slave's count and read data back to the master. Until the first request after reset, the master sees a count of zero and read data of zero.

This bus has no valid/ready handshake at its edge. A strobe is accepted unconditionally. Back-pressure is expressed only through the returned count, and the master must wait for a zero count before it treats the transaction as complete. A new strobe may be issued in the same cycle the count reads zero.

Top module: `mio_split_decoder`

## Requirements
- R1: A strobe with address bit 22 equal to 0 drives the memory port's read/write strobes equal to the master's strobes, and holds both IO strobes at 0 in that cycle.
- R2: A strobe with address bit 22 equal to 1 drives the IO port's read/write strobes equal to the master's strobes, and holds both memory strobes at 0 in that cycle.
- R3: The memory port address equals master address bits 20..0. Bit 21 has no effect on it, so memory appears twice in the lower half of the map.
- R4: The IO port address equals master address bits 6..0.
- R5: Write data, the atomic flag and the non-cacheable flag appear unchanged on both slave ports in the same cycle.
- R6: From the cycle after a strobe until the next strobe, the master's ready count and read data equal those of the slave that strobe selected. The other slave's count and data have no effect.
- R7: After reset and before any strobe, the master's ready count is 0 and its read data is 0, whatever the slaves drive.
- R8: A strobe issued in the same cycle that the current owner reports a count of 0 takes effect at once. From the next cycle, responses come from the newly selected slave.
- R9: Address and flag values in cycles without a strobe do not change the recorded owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | 23 | Master address, bit 22 selects IO |
| m_wdata | input | 32 | Master write data |
| m_rd | input | 1 | Master read strobe, one cycle |
| m_wr | input | 1 | Master write strobe, one cycle |
| m_atomic | input | 1 | Master atomic-access flag |
| m_nocache | input | 1 | Master non-cacheable flag |
| m_rdata | output | 32 | Read data returned to master |
| m_rcnt | output | 2 | Ready count returned to master |
| mem_addr | output | 21 | Memory slave address |
| mem_wdata | output | 32 | Memory slave write data |
| mem_rd | output | 1 | Memory slave read strobe |
| mem_wr | output | 1 | Memory slave write strobe |
| mem_atomic | output | 1 | Memory slave atomic flag |
| mem_nocache | output | 1 | Memory slave non-cacheable flag |
| mem_rdata | input | 32 | Memory slave read data |
| mem_rcnt | input | 2 | Memory slave ready count |
| io_addr | output | 7 | IO slave address |
| io_wdata | output | 32 | IO slave write data |
| io_rd | output | 1 | IO slave read strobe |
| io_wr | output | 1 | IO slave write strobe |
| io_atomic | output | 1 | IO slave atomic flag |
| io_nocache | output | 1 | IO slave non-cacheable flag |
| io_rdata | input | 32 | IO slave read data |
| io_rcnt | input | 2 | IO slave ready count |

## Verification
On every cycle, the assertions check strobe exclusivity between the two slaves. They also check that the owner register follows the select bit of each strobe and holds otherwise, and that the returned count is zero before the first request. Only the bench's scenarios show the following:
- address truncation and mirroring across the sweep of addresses;
- that the non-owning slave's responses really are ignored;
- the same-cycle handover of ownership.

// File: rtl/mio_split_pkg.sv
package mio_split_pkg;
  localparam int unsigned ADDR_W_DEF  = 23;
  localparam int unsigned DATA_W_DEF  = 32;
  localparam int unsigned MEM_AW_DEF  = 21;
  localparam int unsigned IO_AW_DEF   = 7;
  localparam int unsigned CNT_W_DEF   = 2;

  typedef enum logic {
    OWN_MEM = 1'b0,
    OWN_IO  = 1'b1
  } owner_e;
endpackage

// File: rtl/sbd_req_router.sv
module sbd_req_router #(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned MEM_AW = 21,
  parameter int unsigned IO_AW  = 7,
  localparam int unsigned SEL_BIT = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output mio_split_pkg::owner_e sel,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [IO_AW-1:0]  io_addr,
  output logic              io_rd,
  output logic              io_wr
);
  import mio_split_pkg::*;

  logic pick_io;

  always_comb begin
    pick_io  = addr[SEL_BIT];
    sel      = pick_io ? OWN_IO : OWN_MEM;
    mem_addr = addr[MEM_AW-1:0];
    io_addr  = addr[IO_AW-1:0];
    mem_rd   = rd & ~pick_io;
    mem_wr   = wr & ~pick_io;
    io_rd    = rd & pick_io;
    io_wr    = wr & pick_io;
  end

  // R1 / R2: never both slaves strobed in one cycle
  p_excl_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_rd | mem_wr) && (io_rd | io_wr)));
  p_io_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd | wr) && !addr[SEL_BIT]) |-> (!io_rd && !io_wr));
  p_mem_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd | wr) && addr[SEL_BIT]) |-> (!mem_rd && !mem_wr));
endmodule

// File: rtl/sbd_owner_track.sv
module sbd_owner_track (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  mio_split_pkg::owner_e sel,
  output mio_split_pkg::owner_e owner,
  output logic                  issued
);
  import mio_split_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner  <= OWN_MEM;
      issued <= 1'b0;
    end else if (strobe) begin
      owner  <= sel;
      issued <= 1'b1;
    end
  end

  // R6 / R8: owner follows the select of every strobe
  p_owner_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (owner == $past(sel)));
  // R9: owner holds between strobes
  p_owner_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(owner) && $stable(issued)));
endmodule

// File: rtl/sbd_resp_mux.sv
module sbd_resp_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 2
) (
  input  mio_split_pkg::owner_e owner,
  input  logic                  issued,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic [CNT_W-1:0]      mem_rcnt,
  input  logic [DATA_W-1:0]     io_rdata,
  input  logic [CNT_W-1:0]      io_rcnt,
  output logic [DATA_W-1:0]     m_rdata,
  output logic [CNT_W-1:0]      m_rcnt
);
  import mio_split_pkg::*;

  always_comb begin
    m_rdata = '0;
    m_rcnt  = '0;
    if (issued) begin
      unique case (owner)
        OWN_IO: begin
          m_rdata = io_rdata;
          m_rcnt  = io_rcnt;
        end
        default: begin
          m_rdata = mem_rdata;
          m_rcnt  = mem_rcnt;
        end
      endcase
    end
  end
endmodule

// File: rtl/mio_split_decoder.sv
module mio_split_decoder #(
  parameter int unsigned ADDR_W = mio_split_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = mio_split_pkg::DATA_W_DEF,
  parameter int unsigned MEM_AW = mio_split_pkg::MEM_AW_DEF,
  parameter int unsigned IO_AW  = mio_split_pkg::IO_AW_DEF,
  parameter int unsigned CNT_W  = mio_split_pkg::CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic              m_rd,
  input  logic              m_wr,
  input  logic              m_atomic,
  input  logic              m_nocache,
  output logic [DATA_W-1:0] m_rdata,
  output logic [CNT_W-1:0]  m_rcnt,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_atomic,
  output logic              mem_nocache,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CNT_W-1:0]  mem_rcnt,
  output logic [IO_AW-1:0]  io_addr,
  output logic [DATA_W-1:0] io_wdata,
  output logic              io_rd,
  output logic              io_wr,
  output logic              io_atomic,
  output logic              io_nocache,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [CNT_W-1:0]  io_rcnt
);
  import mio_split_pkg::*;

  owner_e sel, owner;
  logic   issued;
  logic   strobe;

  assign strobe = m_rd | m_wr;

  sbd_req_router #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .IO_AW(IO_AW)) router_i (
    .clk(clk), .rst_n(rst_n), .addr(m_addr), .rd(m_rd), .wr(m_wr), .sel(sel),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr)
  );

  sbd_owner_track owner_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel(sel),
    .owner(owner), .issued(issued)
  );

  sbd_resp_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) mux_i (
    .owner(owner), .issued(issued),
    .mem_rdata(mem_rdata), .mem_rcnt(mem_rcnt),
    .io_rdata(io_rdata), .io_rcnt(io_rcnt),
    .m_rdata(m_rdata), .m_rcnt(m_rcnt)
  );

  // R5: side information goes to both ports
  assign mem_wdata   = m_wdata;
  assign io_wdata    = m_wdata;
  assign mem_atomic  = m_atomic;
  assign io_atomic   = m_atomic;
  assign mem_nocache = m_nocache;
  assign io_nocache  = m_nocache;

  // R7: nothing returned before the first request
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !issued |-> (m_rcnt == '0 && m_rdata == '0));
  // R6: after an IO request the count comes from the IO slave
  p_io_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd | io_wr) |=> (m_rcnt == io_rcnt));
  p_mem_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd | mem_wr) |=> (m_rcnt == mem_rcnt));
endmodule

// File: tb/mio_split_decoder_tb_top.sv
module mio_split_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic        m_rd = 1'b0, m_wr = 1'b0, m_atomic = 1'b0, m_nocache = 1'b0;
  logic [31:0] m_rdata;
  logic [1:0]  m_rcnt;
  logic [20:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rd, mem_wr, mem_atomic, mem_nocache;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  mem_rcnt = '0;
  logic [6:0]  io_addr;
  logic [31:0] io_wdata;
  logic        io_rd, io_wr, io_atomic, io_nocache;
  logic [31:0] io_rdata = '0;
  logic [1:0]  io_rcnt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mio_split_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wdata(m_wdata), .m_rd(m_rd),
    .m_wr(m_wr), .m_atomic(m_atomic), .m_nocache(m_nocache), .m_rdata(m_rdata),
    .m_rcnt(m_rcnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_atomic(mem_atomic), .mem_nocache(mem_nocache),
    .mem_rdata(mem_rdata), .mem_rcnt(mem_rcnt), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr), .io_atomic(io_atomic),
    .io_nocache(io_nocache), .io_rdata(io_rdata), .io_rcnt(io_rcnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Issue one strobe at the falling edge and check the forwarding.
  task automatic issue(input logic [22:0] a, input bit is_wr, input int k);
    logic is_io;
    @(negedge clk);
    m_addr = a; m_rd = !is_wr; m_wr = is_wr;
    m_wdata = 32'h9E37_79B9 * (k + 1);
    m_atomic = k[0]; m_nocache = k[1];
    #1;
    is_io = a[22];
    chk(is_io ? "R2 io_rd" : "R1 mem_rd", is_io ? {63'd0, io_rd} : {63'd0, mem_rd}, {63'd0, !is_wr});
    chk(is_io ? "R2 io_wr" : "R1 mem_wr", is_io ? {63'd0, io_wr} : {63'd0, mem_wr}, {63'd0, is_wr});
    chk(is_io ? "R2 mem quiet" : "R1 io quiet",
        is_io ? {62'd0, mem_rd, mem_wr} : {62'd0, io_rd, io_wr}, 64'd0);
    chk("R3 mem_addr", {43'd0, mem_addr}, {43'd0, a % (1 << 21)});
    chk("R4 io_addr", {57'd0, io_addr}, {57'd0, a % 128});
    chk("R5 wdata", {mem_wdata, io_wdata}, {m_wdata, m_wdata});
    chk("R5 flags", {60'd0, mem_atomic, io_atomic, mem_nocache, io_nocache},
        {60'd0, k[0], k[0], k[1], k[1]});
  endtask

  // Quiet cycle: drive slave responses, scramble the address, check routing.
  task automatic respond(input bit owner_io, input logic [1:0] mc, input logic [1:0] ic, input int k);
    @(negedge clk);
    m_rd = 1'b0; m_wr = 1'b0;
    m_addr = {~owner_io, 22'h2A_5A5A ^ k[21:0]};   // R9: opposite select, no strobe
    mem_rcnt = mc; io_rcnt = ic;
    mem_rdata = 32'h1000_0000 + k; io_rdata = 32'h2000_0000 + k;
    #1;
    chk("R6 rcnt", {62'd0, m_rcnt}, {62'd0, owner_io ? ic : mc});
    chk("R6 rdata", {32'd0, m_rdata}, {32'd0, owner_io ? io_rdata : mem_rdata});
  endtask

  initial begin
    mem_rcnt = 2'd3; io_rcnt = 2'd2; mem_rdata = 32'hDEAD_0001; io_rdata = 32'hDEAD_0002;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R7 idle rcnt", {62'd0, m_rcnt}, 64'd0);
    chk("R7 idle rdata", {32'd0, m_rdata}, 64'd0);
    chk("R1 idle strobes", {60'd0, mem_rd, mem_wr, io_rd, io_wr}, 64'd0);

    // Sweep: select bit, mirror bit, low patterns, read/write
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 2; b++) begin
        for (int p = 0; p < 8; p++) begin
          for (int w = 0; w < 2; w++) begin
            int k;
            logic [22:0] a;
            k = ((s * 2 + b) * 8 + p) * 2 + w;
            a = {s[0], b[0], 21'((p * 21'h0B_5A3D) ^ (p << 17))};
            issue(a, w[0], k);
            respond(s[0], 2'((k + 1) % 4), 2'((k + 3) % 4), k);
            respond(s[0], 2'd0, 2'((k % 3) + 1), k + 100);    // R6 completion, other busy
            respond(s[0], 2'd0, 2'd0, k + 200);               // R9 still same owner
          end
        end
      end
    end

    // R3 mirroring: same low bits, bit 21 toggled, identical memory address
    issue(23'h20_1234, 1'b0, 5);
    chk("R3 mirror", {43'd0, mem_addr}, 64'h1234);
    issue(23'h00_1234, 1'b1, 6);
    chk("R3 mirror low", {43'd0, mem_addr}, 64'h1234);

    // R8: IO owner reports zero while a memory strobe is issued, then swap back
    issue(23'h40_0011, 1'b0, 7);
    @(negedge clk);
    m_rd = 1'b0; io_rcnt = 2'd0; mem_rcnt = 2'd3;
    m_addr = 23'h00_0100; m_wr = 1'b1;
    #1;
    chk("R8 io done", {62'd0, m_rcnt}, 64'd0);
    @(negedge clk);
    m_wr = 1'b0; mem_rcnt = 2'd2; io_rcnt = 2'd1; #1;
    chk("R8 mem owns", {62'd0, m_rcnt}, 64'd2);
    mem_rcnt = 2'd0; m_addr = 23'h40_0022; m_rd = 1'b1; #1;
    chk("R8 mem done", {62'd0, m_rcnt}, 64'd0);
    @(negedge clk);
    m_rd = 1'b0; mem_rcnt = 2'd3; io_rcnt = 2'd1; #1;
    chk("R8 io owns", {62'd0, m_rcnt}, 64'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule